// File: doc/BRIEF.md
# Twiddled Texture Address Generator

This block converts a pixel coordinate inside one mip level into a byte offset from the start of that level. It supports two memory layouts. In the linear layout, rows follow each other at a programmable pitch. In the twiddled layout, the level is cut into power-of-two tiles that are laid out row after row, and the elements inside each tile follow a Morton (Z-order) sequence.

The tile shape depends on the element size. A full tile always holds exactly 16 KiB. Levels too small to hold a full tile use a reduced square tile instead. The request carries the coordinate, the base-2 logarithm of the bytes per element, the level's width and height, a row pitch, and a layout select. One clock later the result appears, with a flag that says whether the request was legal. A texture sampler or a copy engine issues one lookup per cycle. Adding the level's base address is the caller's job.

Top module: `twiddle_addr_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid is 0 and out_offset is 0.
- R2: A request presented with req_valid high produces its result on the next rising clock edge. A cycle with req_valid low produces out_valid 0 and out_offset 0 on the next edge. Whenever out_valid is 0, out_offset is 0.
- R3: With layout_sel 0 (linear), out_offset = y * stride + x * 2^bpb_log2.
- R4: With layout_sel 0, a stride of zero or a stride whose low four bits are not all zero gives out_valid 0.
- R5: bpb_log2 codes 0 to 4 (1, 2, 4, 8, 16 bytes per element) are legal. Codes 5 to 7 give out_valid 0 in both layouts.
- R6: With layout_sel 1 (twiddled), a large level uses a tile of width x height elements as follows: 128x128 for code 0, 128x64 for code 1, 64x64 for code 2, 64x32 for code 3, and 32x32 for code 4. Each such tile occupies exactly 16384 bytes.
- R7: Tiles are numbered in raster order. The tiles per row equal the width divided by the tile width, rounded up. The offset is (tile_index * tile_elements + index_within_tile) * 2^bpb_log2.
- R8: Inside a tile, x bit i goes to index bit 2i and y bit i goes to index bit 2i+1, for every i below log2 of the tile height. When the tile is twice as wide as it is tall, the remaining x bit goes to index bit 2*log2(tile height).
- R9: A level is small when its width is below the large tile width or its height is below the large tile height. A small level uses a square tile whose side is the smallest power of two that is at least min(width, height).
- R10: With layout_sel 1, the stride input is ignored. Any stride, including an illegal one, gives a valid result.
- R11: With layout_sel 1, a width or height of zero gives out_valid 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| layout_sel | input | 1 | 0 = linear, 1 = twiddled |
| bpb_log2 | input | 3 | log2 of bytes per element |
| x | input | COORD_W | Column of the element |
| y | input | COORD_W | Row of the element |
| width | input | COORD_W | Level width in elements |
| height | input | COORD_W | Level height in elements |
| stride | input | STRIDE_W | Linear row pitch in bytes |
| out_valid | output | 1 | Registered result is legal |
| out_offset | output | OFFS_W | Registered byte offset within the level |

## Verification
The bench targets the boundary where a level switches between large and small tiles. A design that decides "small" from only one axis would give a 20x300 level a 64x64 tile, and the offsets of its second tile row would come out wrong.

The rectangular tile shapes of codes 1 and 3 are probed at the x bit just above the interleaved bits. A design that interleaves that bit, or drops it, produces offsets that collide with other elements or go past the 16 KiB tile.

Widths that are not a multiple of the tile width check the rounding of the tiles per row. Truncating instead of rounding up shifts every later tile row back by one tile.

Strides such as 0 and 24, and block size codes above 4, check that the legality rules apply only in their own layout.

// File: rtl/twaddr_pkg.sv
package twaddr_pkg;

    typedef enum logic {
        LAYOUT_LINEAR   = 1'b0,
        LAYOUT_TWIDDLED = 1'b1
    } layout_e;

    localparam int unsigned PAGE_BYTES_LOG2 = 14;
    localparam int unsigned MAX_BPB_LOG2    = 4;
    localparam int unsigned STRIDE_ALIGN_B  = 4;

    typedef struct packed {
        logic [5:0] w_log2;
        logic [5:0] h_log2;
    } tile_shape_t;

endpackage

// File: rtl/twaddr_tile_shape.sv
module twaddr_tile_shape
    import twaddr_pkg::*;
#(
    parameter int COORD_W = 16
) (
    input  logic [2:0]         bpb_log2,
    input  logic [COORD_W-1:0] width,
    input  logic [COORD_W-1:0] height,
    output tile_shape_t        shape,
    output logic               is_small
);

    localparam int CMP_W = COORD_W + 1;

    function automatic logic [5:0] ceil_log2(input logic [COORD_W-1:0] v);
        logic [5:0] r;
        r = '0;
        for (int k = 0; k < COORD_W; k++) begin
            if ((CMP_W'(1) << k) < {1'b0, v}) r = 6'(k + 1);
        end
        return r;
    endfunction

    logic [5:0]         big_w, big_h, side;
    logic [CMP_W-1:0]   big_w_span, big_h_span;
    logic [COORD_W-1:0] minor;

    always_comb begin
        // Page-filling tile: width shrinks on even codes, height on odd ones
        big_w = 6'd7 - {4'b0, bpb_log2[2:1]};
        big_h = 6'd7 - 6'(({1'b0, bpb_log2} + 4'd1) >> 1);
        big_w_span = CMP_W'(1) << big_w;
        big_h_span = CMP_W'(1) << big_h;
        is_small = ({1'b0, width} < big_w_span) || ({1'b0, height} < big_h_span);
        minor = (width < height) ? width : height;
        side  = ceil_log2(minor);
        if (is_small) begin
            shape.w_log2 = side;
            shape.h_log2 = side;
        end else begin
            shape.w_log2 = big_w;
            shape.h_log2 = big_h;
        end
    end

    // Large tiles fill one page exactly (R6)
    always_comb begin
        if (!is_small && bpb_log2 <= 3'(MAX_BPB_LOG2)) begin
            p_tile_page_r6: assert (32'(big_w) + 32'(big_h) + 32'(bpb_log2) == PAGE_BYTES_LOG2);
        end
    end

    // Tile is square or twice as wide as tall (R6, R9)
    always_comb begin
        if (bpb_log2 <= 3'(MAX_BPB_LOG2)) begin
            p_tile_aspect_r9: assert (shape.w_log2 == shape.h_log2 ||
                                      shape.w_log2 == shape.h_log2 + 6'd1);
        end
    end

endmodule

// File: rtl/twaddr_morton.sv
module twaddr_morton
    import twaddr_pkg::*;
#(
    parameter int COORD_W = 16
) (
    input  logic [COORD_W-1:0]   x,
    input  logic [COORD_W-1:0]   y,
    input  tile_shape_t          shape,
    output logic [2*COORD_W-1:0] inner
);

    localparam int IDX_W = 2 * COORD_W;

    logic [IDX_W-1:0] lane_bits [COORD_W];

    for (genvar i = 0; i < COORD_W; i++) begin : g_lane
        always_comb begin
            lane_bits[i] = '0;
            if (6'(i) < shape.h_log2) begin
                lane_bits[i][2*i]   = x[i];
                lane_bits[i][2*i+1] = y[i];
            end else if (6'(i) == shape.h_log2 && shape.w_log2 > shape.h_log2) begin
                lane_bits[i][2*i] = x[i];
            end
        end
    end

    always_comb begin
        inner = '0;
        for (int i = 0; i < COORD_W; i++) inner = inner | lane_bits[i];
    end

    // The index within a tile never reaches past the tile (R8)
    always_comb begin
        if (32'(shape.w_log2) + 32'(shape.h_log2) < IDX_W) begin
            p_inner_bound_r8: assert ((inner >> (shape.w_log2 + shape.h_log2)) == '0);
        end
    end

endmodule

// File: rtl/twiddle_addr_gen.sv
module twiddle_addr_gen
    import twaddr_pkg::*;
#(
    parameter int COORD_W  = 16,
    parameter int STRIDE_W = COORD_W + 4,
    localparam int OFFS_W  = ((COORD_W + STRIDE_W > 2 * COORD_W + 2) ?
                              COORD_W + STRIDE_W : 2 * COORD_W + 2) + 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                layout_sel,
    input  logic [2:0]          bpb_log2,
    input  logic [COORD_W-1:0]  x,
    input  logic [COORD_W-1:0]  y,
    input  logic [COORD_W-1:0]  width,
    input  logic [COORD_W-1:0]  height,
    input  logic [STRIDE_W-1:0] stride,
    output logic                out_valid,
    output logic [OFFS_W-1:0]   out_offset
);

    layout_e              layout;
    tile_shape_t          shape;
    logic                 small_level;
    logic [2*COORD_W-1:0] inner;

    logic                 bpb_ok, stride_ok, dims_ok, next_valid;
    logic [OFFS_W-1:0]    lin_off, tw_off, next_off;
    logic [OFFS_W-1:0]    tile_span, tiles_per_row, tile_idx, elem_idx;

    assign layout = layout_e'(layout_sel);

    twaddr_tile_shape #(.COORD_W(COORD_W)) u_shape (
        .bpb_log2 (bpb_log2),
        .width    (width),
        .height   (height),
        .shape    (shape),
        .is_small (small_level)
    );

    twaddr_morton #(.COORD_W(COORD_W)) u_morton (
        .x     (x),
        .y     (y),
        .shape (shape),
        .inner (inner)
    );

    always_comb begin
        bpb_ok    = bpb_log2 <= 3'(MAX_BPB_LOG2);
        stride_ok = (stride != '0) && (stride[STRIDE_ALIGN_B-1:0] == '0);
        dims_ok   = (width != '0) && (height != '0);

        lin_off = OFFS_W'(y) * OFFS_W'(stride) + (OFFS_W'(x) << bpb_log2);

        tile_span     = OFFS_W'(1) << shape.w_log2;
        tiles_per_row = (OFFS_W'(width) + tile_span - OFFS_W'(1)) >> shape.w_log2;
        tile_idx      = (OFFS_W'(y) >> shape.h_log2) * tiles_per_row
                      + (OFFS_W'(x) >> shape.w_log2);
        elem_idx      = (tile_idx << (shape.w_log2 + shape.h_log2)) | OFFS_W'(inner);
        tw_off        = elem_idx << bpb_log2;

        unique case (layout)
            LAYOUT_LINEAR: begin
                next_valid = req_valid && bpb_ok && stride_ok;
                next_off   = lin_off;
            end
            LAYOUT_TWIDDLED: begin
                next_valid = req_valid && bpb_ok && dims_ok;
                next_off   = tw_off;
            end
            default: begin
                next_valid = 1'b0;
                next_off   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_offset <= '0;
        end else begin
            out_valid  <= next_valid;
            out_offset <= next_valid ? next_off : '0;
        end
    end

    p_valid_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(req_valid));

    p_bad_bpb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bpb_log2 > 3'(MAX_BPB_LOG2)) |=> !out_valid);

    p_bad_stride_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !layout_sel && (stride == '0 || stride[STRIDE_ALIGN_B-1:0] != '0))
        |=> !out_valid);

    p_zero_dims_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && layout_sel && (width == '0 || height == '0)) |=> !out_valid);

    p_good_tw_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && layout_sel && width != '0 && height != '0 &&
         bpb_log2 <= 3'(MAX_BPB_LOG2)) |=> out_valid);

endmodule

// File: tb/twiddle_addr_gen_tb_top.sv
`timescale 1ns/1ps
module twiddle_addr_gen_tb_top;

    localparam int COORD_W  = 16;
    localparam int STRIDE_W = 20;
    localparam int OFFS_W   = 41;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                req_valid = 1'b0;
    logic                layout_sel = 1'b0;
    logic [2:0]          bpb_log2 = '0;
    logic [COORD_W-1:0]  x = '0, y = '0, width = '0, height = '0;
    logic [STRIDE_W-1:0] stride = '0;
    logic                out_valid;
    logic [OFFS_W-1:0]   out_offset;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    twiddle_addr_gen #(.COORD_W(COORD_W), .STRIDE_W(STRIDE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .layout_sel(layout_sel),
        .bpb_log2(bpb_log2), .x(x), .y(y), .width(width), .height(height),
        .stride(stride), .out_valid(out_valid), .out_offset(out_offset)
    );

    function automatic longint model(input bit lay, input int px, input int py,
                                     input int w, input int h, input int bpb,
                                     input int st, output bit ok);
        int lw, lh, mn, s;
        longint tpr, tile, m, lx, ly;
        ok = (bpb <= 4) && (lay ? (w != 0 && h != 0) : (st != 0 && st % 16 == 0));
        if (!ok) return 0;
        if (!lay) return longint'(py) * st + longint'(px) * (1 << bpb);
        case (bpb)
            0: begin lw = 7; lh = 7; end
            1: begin lw = 7; lh = 6; end
            2: begin lw = 6; lh = 6; end
            3: begin lw = 6; lh = 5; end
            default: begin lw = 5; lh = 5; end
        endcase
        if (w < (1 << lw) || h < (1 << lh)) begin
            mn = (w < h) ? w : h;
            s = 0;
            while ((1 << s) < mn) s++;
            lw = s; lh = s;
        end
        tpr  = (w + (1 << lw) - 1) / (1 << lw);
        tile = longint'(py / (1 << lh)) * tpr + px / (1 << lw);
        lx = px % (1 << lw);
        ly = py % (1 << lh);
        m = 0;
        for (int b = 0; b < lh; b++) begin
            m |= ((lx >> b) & 1) << (2 * b);
            m |= ((ly >> b) & 1) << (2 * b + 1);
        end
        if (lw > lh) m |= ((lx >> lh) & 1) << (2 * lh);
        return ((tile << (lw + lh)) + m) << bpb;
    endfunction

    task automatic check(input string tag, input bit ev, input longint eo);
        n_checks++;
        if (out_valid !== ev || out_offset !== OFFS_W'(eo)) begin
            n_fail++;
            $display("FAIL %s: valid=%0b offset=%0d expected valid=%0b offset=%0d",
                     tag, out_valid, out_offset, ev, eo);
        end
    endtask

    task automatic run(input string tag, input bit lay, input int px, input int py,
                       input int w, input int h, input int bpb, input int st);
        bit ok;
        longint eo;
        @(negedge clk);
        req_valid = 1'b1; layout_sel = lay; bpb_log2 = 3'(bpb);
        x = 16'(px); y = 16'(py); width = 16'(w); height = 16'(h); stride = 20'(st);
        eo = model(lay, px, py, w, h, bpb, st, ok);
        @(negedge clk);
        check(tag, ok, eo);
    endtask

    task automatic run_exp(input string tag, input bit lay, input int px, input int py,
                           input int w, input int h, input int bpb, input int st,
                           input bit ev, input longint eo);
        @(negedge clk);
        req_valid = 1'b1; layout_sel = lay; bpb_log2 = 3'(bpb);
        x = 16'(px); y = 16'(py); width = 16'(w); height = 16'(h); stride = 20'(st);
        @(negedge clk);
        check(tag, ev, eo);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        int lw;
        int tpr;
        int w, h, b, st, px, py;
        bit lay;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 in reset", 1'b0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 1'b0, 0);

        // R2: one-cycle latency, idle cycle yields zeroes
        run_exp("R3 linear basic", 1'b0, 3, 2, 10, 10, 2, 64, 1'b1, 140);
        @(negedge clk); req_valid = 1'b0;
        @(negedge clk);
        check("R2 idle after request", 1'b0, 0);

        // R4 stride legality
        run_exp("R4 zero stride", 1'b0, 1, 1, 10, 10, 0, 0, 1'b0, 0);
        run_exp("R4 unaligned stride", 1'b0, 1, 1, 10, 10, 0, 24, 1'b0, 0);
        run_exp("R3 bpb16 linear", 1'b0, 5, 7, 10, 10, 4, 4096, 1'b1, 7 * 4096 + 80);

        // R5 illegal block codes
        run_exp("R5 code5 linear", 1'b0, 0, 0, 64, 64, 5, 64, 1'b0, 0);
        run_exp("R5 code7 twiddled", 1'b1, 0, 0, 256, 256, 7, 64, 1'b0, 0);

        // R6 tile dimensions: next tile to the right starts one page later
        for (int c = 0; c <= 4; c++) begin
            lw = 7 - c / 2;
            run_exp($sformatf("R6 tile width code%0d", c), 1'b1, 1 << lw, 0, 256, 256, c, 0,
                    1'b1, 16384);
            tpr = 256 >> lw;
            run_exp($sformatf("R6 tile height code%0d", c), 1'b1, 0, 1 << (7 - (c + 1) / 2),
                    256, 256, c, 0, 1'b1, longint'(tpr) * 16384);
        end

        // R8 Morton ordering
        run_exp("R8 x bit0", 1'b1, 1, 0, 128, 128, 0, 0, 1'b1, 1);
        run_exp("R8 y bit0", 1'b1, 0, 1, 128, 128, 0, 0, 1'b1, 2);
        run_exp("R8 x3y3", 1'b1, 3, 3, 128, 128, 0, 0, 1'b1, 15);
        run_exp("R8 rect extra x bit", 1'b1, 64, 0, 256, 256, 1, 0, 1'b1, 8192);
        run_exp("R8 rect code3 extra", 1'b1, 32, 0, 128, 128, 3, 0, 1'b1, 8192);

        // R9 small levels
        run_exp("R9 small next row", 1'b1, 0, 32, 20, 300, 2, 0, 1'b1, 4096);
        run_exp("R9 small morton", 1'b1, 5, 0, 20, 300, 2, 0, 1'b1, 68);
        run_exp("R9 single column", 1'b1, 0, 3, 1, 9, 0, 0, 1'b1, 3);

        // R7 raster order with non-multiple width
        run_exp("R7 rounded row", 1'b1, 0, 64, 300, 300, 2, 0, 1'b1, 81920);
        run("R7 interior", 1'b1, 299, 130, 300, 300, 2, 0);

        // R10 stride ignored; R11 zero dims
        run_exp("R10 bad stride ignored", 1'b1, 1, 0, 128, 128, 0, 7, 1'b1, 1);
        run_exp("R11 zero width", 1'b1, 0, 0, 0, 50, 0, 0, 1'b0, 0);
        run_exp("R11 zero height", 1'b1, 0, 0, 50, 0, 0, 0, 1'b0, 0);

        // Mixed random requests (R3, R7, R8, R9)
        for (int i = 0; i < 400; i++) begin
            lay = 1'($urandom % 2);
            b   = int'($urandom % 6);
            w   = 1 + int'($urandom % 700);
            h   = 1 + int'($urandom % 700);
            px  = int'($urandom % w);
            py  = int'($urandom % h);
            st  = (int'($urandom % 4096)) * 16;
            if ($urandom % 8 == 0) st = st + 8;
            run(lay ? "R7 R8 R9 random twiddled" : "R3 R4 random linear",
                lay, px, py, w, h, b, st);
        end

        @(negedge clk); req_valid = 1'b0;
        @(negedge clk);
        check("R2 final idle", 1'b0, 0);
        finish_run();
    end

endmodule